// File: doc/BRIEF.md
# Memory Bank Address Decoder

This block turns a 26-bit system address into a single region select for a memory controller. It covers six ROM/SRAM/flash banks, four DRAM banks, four external I/O banks, an internal SRAM window and a special-register window. Each ROM and DRAM bank owns a window from a 10-bit base pointer to a 10-bit next pointer, both counted in 64 KB pages. The four I/O banks sit back to back, 16 KB each, inside one 64 KB page chosen by a single I/O base pointer.

Software loads the configuration through a one-cycle register-write port. The decode itself is purely combinational. Besides the selects, the block gives a no-hit flag and the 2-bit bus width of the region that won. When windows overlap, a fixed priority picks exactly one region. The width of ROM bank 0 comes from two strap pins captured just after reset, so the boot bank's width cannot be rewritten.

Top module: `mbd_addr_decoder`

## Requirements
- R1: ROM bank i (and DRAM bank j) is hit when base<<16 <= addr < next<<16, which means base <= addr[25:16] < next. A next pointer less than or equal to the base leaves the bank empty, so it never selects.
- R2: The I/O region is the 64 KB page where addr[25:16] equals the I/O base. Inside that page, addr[15:14] = k picks I/O bank k, for k from 0 to 3.
- R3: The special-register window covers the whole 64 KB page at its base pointer. It can only hit while its validity bit (register 0 bit 26) is 1.
- R4: The internal SRAM window is 2^SRAM_LOG2 bytes (default 8 KB) starting at sram_base<<16. It hits only while its enable bit (register 0 bit 10) is 1.
- R5: Width codes are 00 = off, 01 = 8-bit, 10 = 16-bit and 11 = 32-bit. A bank whose code is 00 never selects. `sel_width` gives the winning bank's code, 11 for the SRAM and special-register windows, and 00 on a miss.
- R6: ROM bank 0 takes its width from `strap_rom0_w`, captured at the first clock edge after reset. No register write and no later strap change alters it.
- R7: Priority, from highest to lowest, is special registers, SRAM, ROM 0 to 5, DRAM 0 to 3, then I/O 0 to 3. At most one select is high at any time.
- R8: `no_hit` is 1 exactly when no select is high.
- R9: Register map:
  - index 0 holds the SRAM base in [9:0], the SRAM enable in [10], the special-register base in [25:16] and the validity bit in [26];
  - index 1 holds the width codes, 2 bits per field, for ROM1..5 in fields 0..4, DRAM0..3 in fields 5..8 and I/O0..3 in fields 9..12, where field f occupies [2f+1:2f];
  - indices 2..7 are ROM 0..5 and indices 8..11 are DRAM 0..3, each with the base in [9:0] and the next pointer in [25:16];
  - index 12 holds the I/O base in [9:0];
  - writes to indices 13..15 are ignored.
- R10: After reset, all pointers and width fields are 0, the SRAM is disabled and the special-register window is invalid, so every address misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_rom0_w | input | 2 | Width strap for ROM bank 0 |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 4 | Register index |
| cfg_wdata | input | 32 | Register write data |
| addr | input | 26 | System address to decode |
| sel_sfr | output | 1 | Special-register window select |
| sel_sram | output | 1 | Internal SRAM select |
| sel_rom | output | 6 | ROM/SRAM/flash bank selects |
| sel_dram | output | 4 | DRAM bank selects |
| sel_io | output | 4 | External I/O bank selects |
| no_hit | output | 1 | No region matched |
| sel_width | output | 2 | Bus width code of the selected region |

## Verification
The hardest case to reach is a stack of overlapping windows, where several regions claim the same page and only the priority order decides the winner. The bench builds such stacks deliberately: one ROM bank and one DRAM bank span almost the whole space, and the SRAM, special-register, boot-bank and I/O pages sit inside them. It then probes the start, last byte and first byte past every window against a reference model that uses the same order. The strap capture is stressed by changing the pins and writing the width register after reset, then observing the ROM 0 width at the ports.

// File: rtl/mbd_pkg.sv
package mbd_pkg;
  localparam int ADDR_W    = 26;
  localparam int PAGE_LSB  = 16;
  localparam int PTR_W     = ADDR_W - PAGE_LSB;
  localparam int N_ROM     = 6;
  localparam int N_DRAM    = 4;
  localparam int N_IO      = 4;
  localparam int IO_SEL_W  = $clog2(N_IO);
  localparam int DATA_W    = 32;
  localparam int REG_AW    = 4;
  localparam int N_WFIELD  = (N_ROM - 1) + N_DRAM + N_IO;
  localparam int WID_BITS  = 2 * N_WFIELD;
  localparam int N_REGION  = 2 + N_ROM + N_DRAM + N_IO;
  // register indices
  localparam int REG_SYS   = 0;
  localparam int REG_WID   = 1;
  localparam int REG_ROM0  = 2;
  localparam int REG_DRAM0 = REG_ROM0 + N_ROM;
  localparam int REG_IO    = REG_DRAM0 + N_DRAM;
  // field positions inside the system register
  localparam int SRAM_EN_BIT = PTR_W;
  localparam int SFR_V_BIT   = PAGE_LSB + PTR_W;
  // region bit positions in the priority vector (lowest index wins)
  localparam int RG_SFR  = 0;
  localparam int RG_SRAM = 1;
  localparam int RG_ROM  = 2;
  localparam int RG_DRAM = RG_ROM + N_ROM;
  localparam int RG_IO   = RG_DRAM + N_DRAM;

  typedef enum logic [1:0] {W_OFF = 2'b00, W_8 = 2'b01, W_16 = 2'b10, W_32 = 2'b11} width_e;

  typedef struct packed {
    logic [PTR_W-1:0] nxt;
    logic [PTR_W-1:0] base;
  } win_t;
endpackage

// File: rtl/mbd_cfg_regs.sv
module mbd_cfg_regs
  import mbd_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             strap_w,
  input  logic                   we,
  input  logic [REG_AW-1:0]      idx,
  input  logic [DATA_W-1:0]      wdata,
  output logic [PTR_W-1:0]       sram_base,
  output logic                   sram_en,
  output logic [PTR_W-1:0]       sfr_base,
  output logic                   sfr_valid,
  output win_t [N_ROM-1:0]       rom_win,
  output win_t [N_DRAM-1:0]      dram_win,
  output logic [PTR_W-1:0]       io_base,
  output logic [N_ROM-1:0][1:0]  rom_w,
  output logic [N_DRAM-1:0][1:0] dram_w,
  output logic [N_IO-1:0][1:0]   io_w
);
  logic [PTR_W-1:0]    sram_base_q, sram_base_d, sfr_base_q, sfr_base_d, io_base_q, io_base_d;
  logic                sram_en_q, sram_en_d, sfr_valid_q, sfr_valid_d;
  win_t [N_ROM-1:0]    rom_q, rom_d;
  win_t [N_DRAM-1:0]   dram_q, dram_d;
  logic [WID_BITS-1:0] wid_q, wid_d;
  logic [1:0]          strap_q, strap_d;
  logic                strap_done_q, strap_en;
  logic                unused_wdata;

  assign unused_wdata = ^wdata[DATA_W-1:SFR_V_BIT+1];
  assign strap_en     = !strap_done_q;

  // next-state logic
  always_comb begin
    sram_base_d = sram_base_q;
    sram_en_d   = sram_en_q;
    sfr_base_d  = sfr_base_q;
    sfr_valid_d = sfr_valid_q;
    io_base_d   = io_base_q;
    wid_d       = wid_q;
    rom_d       = rom_q;
    dram_d      = dram_q;
    strap_d     = strap_en ? strap_w : strap_q;
    if (we) begin
      if (idx == REG_AW'(REG_SYS)) begin
        sram_base_d = wdata[PTR_W-1:0];
        sram_en_d   = wdata[SRAM_EN_BIT];
        sfr_base_d  = wdata[PAGE_LSB +: PTR_W];
        sfr_valid_d = wdata[SFR_V_BIT];
      end
      if (idx == REG_AW'(REG_WID)) wid_d = wdata[WID_BITS-1:0];
      if (idx == REG_AW'(REG_IO))  io_base_d = wdata[PTR_W-1:0];
      for (int i = 0; i < N_ROM; i++) begin
        if (idx == REG_AW'(REG_ROM0 + i)) begin
          rom_d[i].base = wdata[PTR_W-1:0];
          rom_d[i].nxt  = wdata[PAGE_LSB +: PTR_W];
        end
      end
      for (int j = 0; j < N_DRAM; j++) begin
        if (idx == REG_AW'(REG_DRAM0 + j)) begin
          dram_d[j].base = wdata[PTR_W-1:0];
          dram_d[j].nxt  = wdata[PAGE_LSB +: PTR_W];
        end
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sram_base_q  <= '0;
      sram_en_q    <= 1'b0;
      sfr_base_q   <= '0;
      sfr_valid_q  <= 1'b0;
      io_base_q    <= '0;
      wid_q        <= '0;
      rom_q        <= '0;
      dram_q       <= '0;
      strap_q      <= 2'b00;
      strap_done_q <= 1'b0;
    end else begin
      sram_base_q  <= sram_base_d;
      sram_en_q    <= sram_en_d;
      sfr_base_q   <= sfr_base_d;
      sfr_valid_q  <= sfr_valid_d;
      io_base_q    <= io_base_d;
      wid_q        <= wid_d;
      rom_q        <= rom_d;
      dram_q       <= dram_d;
      strap_q      <= strap_d;
      strap_done_q <= 1'b1;
    end
  end

  assign sram_base = sram_base_q;
  assign sram_en   = sram_en_q;
  assign sfr_base  = sfr_base_q;
  assign sfr_valid = sfr_valid_q;
  assign io_base   = io_base_q;
  assign rom_win   = rom_q;
  assign dram_win  = dram_q;
  assign rom_w[0]  = strap_q;

  for (genvar i = 1; i < N_ROM; i++) begin : g_romw
    assign rom_w[i] = wid_q[2*(i-1) +: 2];
  end
  for (genvar j = 0; j < N_DRAM; j++) begin : g_dramw
    assign dram_w[j] = wid_q[2*(N_ROM-1+j) +: 2];
  end
  for (genvar k = 0; k < N_IO; k++) begin : g_iow
    assign io_w[k] = wid_q[2*(N_ROM-1+N_DRAM+k) +: 2];
  end

  // R6: once captured, the boot bank width never moves
  p_strap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_done_q && $past(strap_done_q)) |-> $stable(strap_q));
endmodule

// File: rtl/mbd_win_cmp.sv
module mbd_win_cmp
  import mbd_pkg::*;
(
  input  logic [PTR_W-1:0] page,
  input  win_t             win,
  input  logic [1:0]       width,
  output logic             hit
);
  // page granular compare: base <= page < next, and the bank must be enabled
  assign hit = (width != W_OFF) && (page >= win.base) && (page < win.nxt);
endmodule

// File: rtl/mbd_prio_sel.sv
module mbd_prio_sel
  import mbd_pkg::*;
(
  input  logic [N_REGION-1:0] raw,
  output logic [N_REGION-1:0] grant,
  output logic                miss
);
  // isolate the lowest set bit: lowest index carries highest priority
  assign grant = raw & (~raw + N_REGION'(1));
  assign miss  = ~|raw;
endmodule

// File: rtl/mbd_addr_decoder.sv
module mbd_addr_decoder
  import mbd_pkg::*;
#(
  parameter int SRAM_LOG2 = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        strap_rom0_w,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_idx,
  input  logic [31:0]       cfg_wdata,
  input  logic [25:0]       addr,
  output logic              sel_sfr,
  output logic              sel_sram,
  output logic [5:0]        sel_rom,
  output logic [3:0]        sel_dram,
  output logic [3:0]        sel_io,
  output logic              no_hit,
  output logic [1:0]        sel_width
);
  localparam int SRAM_HI = PAGE_LSB - 1;

  logic [PTR_W-1:0]       sram_base, sfr_base, io_base, page;
  logic                   sram_en, sfr_valid;
  win_t [N_ROM-1:0]       rom_win;
  win_t [N_DRAM-1:0]      dram_win;
  logic [N_ROM-1:0][1:0]  rom_w;
  logic [N_DRAM-1:0][1:0] dram_w;
  logic [N_IO-1:0][1:0]   io_w;
  logic [N_REGION-1:0]    raw, grant;
  logic [N_REGION-1:0][1:0] region_w;
  logic [IO_SEL_W-1:0]    io_sel;

  mbd_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .strap_w(strap_rom0_w),
    .we(cfg_we), .idx(cfg_idx), .wdata(cfg_wdata),
    .sram_base(sram_base), .sram_en(sram_en), .sfr_base(sfr_base), .sfr_valid(sfr_valid),
    .rom_win(rom_win), .dram_win(dram_win), .io_base(io_base),
    .rom_w(rom_w), .dram_w(dram_w), .io_w(io_w)
  );

  assign page   = addr[ADDR_W-1:PAGE_LSB];
  assign io_sel = addr[PAGE_LSB-1 -: IO_SEL_W];

  assign raw[RG_SFR]       = sfr_valid && (page == sfr_base);
  assign raw[RG_SRAM]      = sram_en && (page == sram_base) && (addr[SRAM_HI:SRAM_LOG2] == '0);
  assign region_w[RG_SFR]  = W_32;
  assign region_w[RG_SRAM] = W_32;

  for (genvar i = 0; i < N_ROM; i++) begin : g_rom
    mbd_win_cmp u_cmp (.page(page), .win(rom_win[i]), .width(rom_w[i]), .hit(raw[RG_ROM+i]));
    assign region_w[RG_ROM+i] = rom_w[i];
  end
  for (genvar j = 0; j < N_DRAM; j++) begin : g_dram
    mbd_win_cmp u_cmp (.page(page), .win(dram_win[j]), .width(dram_w[j]), .hit(raw[RG_DRAM+j]));
    assign region_w[RG_DRAM+j] = dram_w[j];
  end
  for (genvar k = 0; k < N_IO; k++) begin : g_io
    assign raw[RG_IO+k]      = (page == io_base) && (io_sel == IO_SEL_W'(k)) && (io_w[k] != W_OFF);
    assign region_w[RG_IO+k] = io_w[k];
  end

  mbd_prio_sel u_prio (.raw(raw), .grant(grant), .miss(no_hit));

  always_comb begin
    sel_width = W_OFF;
    for (int r = 0; r < N_REGION; r++) begin
      if (grant[r]) sel_width = region_w[r];
    end
  end

  assign sel_sfr  = grant[RG_SFR];
  assign sel_sram = grant[RG_SRAM];
  assign sel_rom  = grant[RG_ROM +: N_ROM];
  assign sel_dram = grant[RG_DRAM +: N_DRAM];
  assign sel_io   = grant[RG_IO +: N_IO];

  // R7: never more than one select
  p_one_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_sfr, sel_sram, sel_rom, sel_dram, sel_io}));
  // R8: miss flag agrees with the selects
  p_miss_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    no_hit == ({sel_sfr, sel_sram, sel_rom, sel_dram, sel_io} == '0));
  // R5: a miss reports no width
  p_miss_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    no_hit |-> (sel_width == W_OFF));
  // R3: invalid special-register field cannot hit
  p_sfr_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sfr_valid |-> !sel_sfr);
  // R4: disabled SRAM window cannot hit
  p_sram_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_en |-> !sel_sram);
  for (genvar i = 0; i < N_ROM; i++) begin : g_arom
    // R1: empty window and R5: disabled bank stay quiet
    p_rom_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (rom_win[i].nxt <= rom_win[i].base) |-> !sel_rom[i]);
    p_rom_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rom_w[i] == W_OFF) |-> !sel_rom[i]);
  end
  for (genvar j = 0; j < N_DRAM; j++) begin : g_adram
    p_dram_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (dram_win[j].nxt <= dram_win[j].base) |-> !sel_dram[j]);
  end
  for (genvar k = 0; k < N_IO; k++) begin : g_aio
    // R2: an I/O select needs the I/O page
    p_io_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sel_io[k] |-> ((page == io_base) && (io_w[k] != W_OFF)));
  end
endmodule

// File: tb/mbd_addr_decoder_tb.sv
`timescale 1ns/1ps
module mbd_addr_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  strap;
  logic        cfg_we;
  logic [3:0]  cfg_idx;
  logic [31:0] cfg_wdata;
  logic [25:0] addr;
  logic        sel_sfr, sel_sram, no_hit;
  logic [5:0]  sel_rom;
  logic [3:0]  sel_dram, sel_io;
  logic [1:0]  sel_width;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mbd_addr_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .strap_rom0_w(strap), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .addr(addr), .sel_sfr(sel_sfr), .sel_sram(sel_sram),
    .sel_rom(sel_rom), .sel_dram(sel_dram), .sel_io(sel_io), .no_hit(no_hit),
    .sel_width(sel_width)
  );

  // shadow of the configuration, kept from the requirements
  logic [9:0] s_sram_b, s_sfr_b, s_io_b;
  logic       s_sram_en, s_sfr_v;
  logic [9:0] s_rom_b[6], s_rom_n[6], s_dr_b[4], s_dr_n[4];
  logic [1:0] s_rom_w[6], s_dr_w[4], s_io_w[4];
  localparam logic [1:0] BOOT_W = 2'b10;

  function automatic int ref_code(logic [25:0] a);
    logic [9:0] pg = a[25:16];
    if (s_sfr_v && pg == s_sfr_b) return 0;
    if (s_sram_en && pg == s_sram_b && a[15:13] == 3'b000) return 1;
    for (int i = 0; i < 6; i++)
      if (s_rom_w[i] != 2'b00 && pg >= s_rom_b[i] && pg < s_rom_n[i]) return 2 + i;
    for (int j = 0; j < 4; j++)
      if (s_dr_w[j] != 2'b00 && pg >= s_dr_b[j] && pg < s_dr_n[j]) return 8 + j;
    if (pg == s_io_b && s_io_w[a[15:14]] != 2'b00) return 12 + int'(a[15:14]);
    return 16;
  endfunction

  function automatic logic [1:0] ref_width(int c);
    if (c <= 1) return 2'b11;
    if (c < 8) return s_rom_w[c-2];
    if (c < 12) return s_dr_w[c-8];
    if (c < 16) return s_io_w[c-12];
    return 2'b00;
  endfunction

  task automatic check_addr(int a, string tag);
    logic [15:0] v;
    int got, ones, exp;
    logic [1:0] ew;
    if (a < 0 || a >= (1 << 26)) return;
    @(negedge clk);
    addr = a[25:0];
    #1;
    v = {sel_io, sel_dram, sel_rom, sel_sram, sel_sfr};
    ones = $countones(v);
    got = 16;
    for (int b = 15; b >= 0; b--) if (v[b]) got = b;
    exp = ref_code(a[25:0]);
    ew = ref_width(exp);
    n_chk++;
    if (ones > 1 || got != exp || sel_width != ew || no_hit != (exp == 16)) begin
      n_fail++;
      $display("FAIL %s addr=%h region=%0d(ones=%0d) width=%b miss=%b expected region=%0d width=%b",
               tag, a, got, ones, sel_width, no_hit, exp, ew);
    end
  endtask

  task automatic wr(int idx, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx[3:0]; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (idx == 0) begin
      s_sram_b = d[9:0]; s_sram_en = d[10]; s_sfr_b = d[25:16]; s_sfr_v = d[26];
    end else if (idx == 1) begin
      for (int i = 1; i < 6; i++) s_rom_w[i] = d[2*(i-1) +: 2];
      for (int j = 0; j < 4; j++) s_dr_w[j] = d[2*(5+j) +: 2];
      for (int k = 0; k < 4; k++) s_io_w[k] = d[2*(9+k) +: 2];
    end else if (idx >= 2 && idx <= 7) begin
      s_rom_b[idx-2] = d[9:0]; s_rom_n[idx-2] = d[25:16];
    end else if (idx >= 8 && idx <= 11) begin
      s_dr_b[idx-8] = d[9:0]; s_dr_n[idx-8] = d[25:16];
    end else if (idx == 12) begin
      s_io_b = d[9:0];
    end
  endtask

  function automatic logic [31:0] win_word(int b, int n);
    return {6'b0, n[9:0], 6'b0, b[9:0]};
  endfunction

  function automatic logic [31:0] wid_word(logic [1:0] r[6], logic [1:0] d[4], logic [1:0] io[4]);
    logic [31:0] w = '0;
    for (int i = 1; i < 6; i++) w[2*(i-1) +: 2] = r[i];
    for (int j = 0; j < 4; j++) w[2*(5+j) +: 2] = d[j];
    for (int k = 0; k < 4; k++) w[2*(9+k) +: 2] = io[k];
    return w;
  endfunction

  task automatic sweep_win(int b, int n, string tag);
    int lo = b << 16;
    int hi = n << 16;
    if (n <= b) begin
      check_addr(lo, tag);
      return;
    end
    check_addr(lo - 1, tag);
    check_addr(lo, tag);
    check_addr(hi - 1, tag);
    check_addr(hi, tag);
  endtask

  task automatic sweep_all();
    for (int i = 0; i < 6; i++) sweep_win(int'(s_rom_b[i]), int'(s_rom_n[i]), "R1 rom");
    for (int j = 0; j < 4; j++) sweep_win(int'(s_dr_b[j]), int'(s_dr_n[j]), "R1 dram");
    for (int k = 0; k < 4; k++) begin
      check_addr((int'(s_io_b) << 16) + k * 16'h4000, "R2 io start");
      check_addr((int'(s_io_b) << 16) + k * 16'h4000 + 16'h3FFF, "R2 io end");
    end
    check_addr((int'(s_io_b) << 16) - 1, "R2 io below");
    check_addr((int'(s_io_b) + 1) << 16, "R2 io above");
    check_addr(int'(s_sram_b) << 16, "R4 sram start");
    check_addr((int'(s_sram_b) << 16) + 16'h1FFF, "R4 sram end-1");
    check_addr((int'(s_sram_b) << 16) + 16'h2000, "R4 sram end");
    sweep_win(int'(s_sfr_b), int'(s_sfr_b) + 1, "R3 sfr");
  endtask

  // R10: reset leaves everything unmapped
  task automatic t_reset();
    check_addr(0, "R10 reset");
    check_addr(26'h3FF0000, "R10 reset");
    check_addr(26'h3FE0000, "R10 reset");
    check_addr(26'h1234567, "R10 reset");
  endtask

  // R1 R5 R9: plain disjoint windows with mixed widths
  task automatic t_windows();
    s_rom_w[1] = 2'b01; s_rom_w[4] = 2'b11; s_dr_w[0] = 2'b11; s_dr_w[3] = 2'b10;
    wr(1, wid_word(s_rom_w, s_dr_w, s_io_w));
    wr(2, win_word(10'h000, 10'h020));
    wr(3, win_word(10'h020, 10'h040));
    wr(6, win_word(10'h100, 10'h180));
    wr(8, win_word(10'h180, 10'h1A0));
    wr(11, win_word(10'h200, 10'h280));
    sweep_all();
  endtask

  // R2: four 16 KB I/O banks, bank 3 switched off
  task automatic t_io();
    s_io_w[0] = 2'b10; s_io_w[1] = 2'b01; s_io_w[2] = 2'b11; s_io_w[3] = 2'b00;
    wr(1, wid_word(s_rom_w, s_dr_w, s_io_w));
    wr(12, 32'h0000_03F0);
    sweep_all();
  endtask

  // R3 R4: internal windows, validity bit off then on
  task automatic t_internal();
    wr(0, {5'b0, 1'b0, 10'h3FF, 5'b0, 1'b1, 10'h3FE});
    check_addr(26'h3FF0000, "R3 sfr invalid");
    check_addr(26'h3FE0000, "R4 sram on");
    wr(0, {5'b0, 1'b1, 10'h3FF, 5'b0, 1'b1, 10'h3FE});
    check_addr(26'h3FF0000, "R3 sfr valid");
    check_addr(26'h3FFFFFF, "R3 sfr last");
    sweep_all();
  endtask

  // R7: large overlapping banks under the small ones
  task automatic t_priority();
    s_rom_w[2] = 2'b01; s_dr_w[1] = 2'b10;
    wr(1, wid_word(s_rom_w, s_dr_w, s_io_w));
    wr(4, win_word(10'h001, 10'h3FF));
    wr(9, win_word(10'h000, 10'h3FF));
    sweep_all();
    check_addr(26'h3F0C000, "R7 io3 off falls to rom2");
    check_addr(26'h0018000, "R7 rom0 over dram1");
  endtask

  // R1: empty windows (next equal or below base)
  task automatic t_empty();
    wr(4, win_word(10'h050, 10'h050));
    wr(9, win_word(10'h060, 10'h040));
    check_addr(26'h0500000, "R1 equal pointers empty");
    check_addr(26'h0500000 + 26'h10000, "R1 equal pointers empty");
    check_addr(26'h0480000, "R1 reversed pointers empty");
    check_addr(26'h0600000, "R1 reversed pointers empty");
    sweep_all();
  endtask

  // R5: turning a width off removes the bank
  task automatic t_disable();
    s_dr_w[0] = 2'b00;
    wr(1, wid_word(s_rom_w, s_dr_w, s_io_w));
    check_addr(26'h1800000, "R5 dram0 off");
    check_addr(26'h19FFFFF, "R5 dram0 off");
    sweep_all();
  endtask

  // R6: boot bank width fixed by the strap
  task automatic t_strap();
    strap = 2'b01;
    wr(1, 32'hFFFF_FFFF);
    check_addr(26'h0000000, "R6 boot width");
    check_addr(26'h01FFFFF, "R6 boot width");
    strap = 2'b00;
    check_addr(26'h0010000, "R6 boot width after strap change");
  endtask

  // R9: indices above the map are dropped
  task automatic t_bad_index();
    wr(13, 32'hFFFF_FFFF);
    wr(14, 32'h0000_0000);
    wr(15, 32'h03FF_0000);
    sweep_all();
  endtask

  initial begin
    rst_n = 1'b0; strap = BOOT_W; cfg_we = 1'b0; cfg_idx = '0; cfg_wdata = '0; addr = '0;
    s_sram_b = '0; s_sfr_b = '0; s_io_b = '0; s_sram_en = 1'b0; s_sfr_v = 1'b0;
    for (int i = 0; i < 6; i++) begin s_rom_b[i] = '0; s_rom_n[i] = '0; s_rom_w[i] = 2'b00; end
    for (int j = 0; j < 4; j++) begin s_dr_b[j] = '0; s_dr_n[j] = '0; s_dr_w[j] = 2'b00; end
    for (int k = 0; k < 4; k++) s_io_w[k] = 2'b00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    s_rom_w[0] = BOOT_W;
    t_reset();
    t_windows();
    t_io();
    t_internal();
    t_priority();
    t_empty();
    t_disable();
    t_strap();
    t_bad_index();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule